// File: doc/BRIEF.md
# Debug Mailbox Channel with Status Word

This block links an external debugger and a processor core through two single-word mailboxes, one per direction. The debugger deposits a word into the inbound mailbox, and the core collects it. The core deposits a word into the outbound mailbox, and the debugger collects it. Each mailbox has a full flag. The flags are set by the depositing side and cleared by the collecting side. Both flags appear in a 32-bit status word, which both sides can read.

The status word also carries a sticky retire indicator. It is set whenever the core reports a retired instruction, so the debugger can tell whether the core has made progress since it last looked. This indicator is read-only in the status word. It can only be cleared by a debugger write to a separate run-control word with its clear bit (bit 3) set. That bit acts as a one-cycle pulse and is never stored.

Every deposit and collect strobe is always accepted in the cycle it is asserted, so the block applies no back-pressure. Flow control is left to the agents, which poll the full flags in the status word before they act. One clock domain is assumed.

Top module: `dbgcc_top`

## Requirements
- R1: After reset the status word is all zero.
- R2: A debugger deposit (`host_rx_wr`) sets status bit 30 on the next cycle, and the deposited word then appears on `core_rx_data`; the flag holds while neither agent touches the inbound mailbox.
- R3: A core collect (`core_rx_rd`) without a same-cycle deposit clears status bit 30 on the next cycle.
- R4: A core deposit (`core_tx_wr`) sets status bit 29 on the next cycle, and the deposited word then appears on `host_tx_data`.
- R5: A debugger collect (`host_tx_rd`) without a same-cycle core deposit clears status bit 29 on the next cycle.
- R6: A core deposit while bit 29 is already set replaces the held word, and bit 29 stays set.
- R7: A core retire pulse sets status bit 25, which then stays set through any activity other than a clear request.
- R8: A run-control write with bit 3 set clears status bit 25; a run-control write with bit 3 clear has no effect on the status word, whatever its other bits hold.
- R9: A retire pulse and a clear request in the same cycle leave bit 25 set.
- R10: A debugger deposit and a core collect in the same cycle leave bit 30 set, with the new word on `core_rx_data`.
- R11: A core deposit and a debugger collect in the same cycle leave bit 29 set, with the new word on `host_tx_data`.
- R12: Status bits 31 and 28:26, and every bit other than 30, 29 and 25, always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rx_wr | input | 1 | Debugger deposits a word into the inbound mailbox |
| host_rx_wdata | input | 32 | Word deposited by the debugger |
| core_rx_rd | input | 1 | Core collects the inbound word |
| core_rx_data | output | 32 | Inbound mailbox contents |
| core_tx_wr | input | 1 | Core deposits a word into the outbound mailbox |
| core_tx_wdata | input | 32 | Word deposited by the core |
| host_tx_rd | input | 1 | Debugger collects the outbound word |
| host_tx_data | output | 32 | Outbound mailbox contents |
| host_ctl_wr | input | 1 | Debugger writes the run-control word |
| host_ctl_data | input | 32 | Run-control word; bit 3 clears the retire indicator |
| core_retire | input | 1 | Pulse: one instruction retired |
| stat_word | output | 32 | Status word, readable by both sides |

## Verification
The hardest situations to reach are the same-cycle collisions. In these, a set request and a clear request for the same flag land on one edge: a deposit together with a collect on either mailbox, and a retire pulse together with a clear request. A random bench rarely produces them. The stimulus therefore first fills each mailbox and sets the retire indicator, and then drives both opposing strobes in one cycle. It then confirms that the flag stays set and that the new word is the one presented. It also sends run-control writes with every bit set except bit 3, to show that only that bit acts.

// File: rtl/dbgcc_pkg.sv
package dbgcc_pkg;
  localparam int STAT_W      = 32;
  localparam int DATA_W      = 32;
  localparam int BIT_RXFULL  = 30;
  localparam int BIT_TXFULL  = 29;
  localparam int BIT_RETIRED = 25;
  localparam int CTL_CLR_BIT = 3;
  localparam int NUM_LIVE    = 3;
endpackage

// File: rtl/dbgcc_mailbox.sv
// One-word mailbox: the filling side sets the flag, the draining side clears
// it, and a fill in the same cycle as a drain wins.
module dbgcc_mailbox #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fill,
  input  logic [W-1:0] fill_data,
  input  logic         drain,
  output logic [W-1:0] word,
  output logic         full
);
  logic [W-1:0] word_q;
  logic         full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else begin
      full_q <= fill | (full_q & ~drain);
      if (fill) word_q <= fill_data;
    end
  end

  assign word = word_q;
  assign full = full_q;
endmodule

// File: rtl/dbgcc_sticky.sv
// Sticky event bit: set beats clear when both arrive together.
module dbgcc_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= set_evt | (flag_q & ~clr_req);
  end

  assign flag = flag_q;
endmodule

// File: rtl/dbgcc_status.sv
// Places the live flags at their fixed positions; every other bit is zero.
module dbgcc_status
  import dbgcc_pkg::*;
(
  input  logic              rx_full,
  input  logic              tx_full,
  input  logic              retired,
  output logic [STAT_W-1:0] stat
);
  localparam int POS [NUM_LIVE] = '{BIT_RXFULL, BIT_TXFULL, BIT_RETIRED};
  logic [NUM_LIVE-1:0] live;

  assign live = {retired, tx_full, rx_full};

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int k = 0; k < NUM_LIVE; k++)
        if (POS[k] == b) hit = live[k];
    end
    assign stat[b] = hit;
  end
endmodule

// File: rtl/dbgcc_top.sv
module dbgcc_top
  import dbgcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rx_wr,
  input  logic [DATA_W-1:0] host_rx_wdata,
  input  logic              core_rx_rd,
  output logic [DATA_W-1:0] core_rx_data,
  input  logic              core_tx_wr,
  input  logic [DATA_W-1:0] core_tx_wdata,
  input  logic              host_tx_rd,
  output logic [DATA_W-1:0] host_tx_data,
  input  logic              host_ctl_wr,
  input  logic [31:0]       host_ctl_data,
  input  logic              core_retire,
  output logic [STAT_W-1:0] stat_word
);
  logic rx_full, tx_full, retired, clr_pulse;
  logic unused_ctl;

  // Only the clear bit of the run-control word acts; it is never stored.
  assign clr_pulse  = host_ctl_wr & host_ctl_data[CTL_CLR_BIT];
  assign unused_ctl = ^{host_ctl_data[31:CTL_CLR_BIT+1], host_ctl_data[CTL_CLR_BIT-1:0]};

  dbgcc_mailbox #(.W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .fill(host_rx_wr), .fill_data(host_rx_wdata), .drain(core_rx_rd),
    .word(core_rx_data), .full(rx_full)
  );

  dbgcc_mailbox #(.W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .fill(core_tx_wr), .fill_data(core_tx_wdata), .drain(host_tx_rd),
    .word(host_tx_data), .full(tx_full)
  );

  dbgcc_sticky u_ret (
    .clk(clk), .rst_n(rst_n),
    .set_evt(core_retire), .clr_req(clr_pulse), .flag(retired)
  );

  dbgcc_status u_stat (
    .rx_full(rx_full), .tx_full(tx_full), .retired(retired), .stat(stat_word)
  );
endmodule

// File: rtl/dbgcc_chk.sv
module dbgcc_chk
  import dbgcc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              host_rx_wr,
  input logic [DATA_W-1:0] host_rx_wdata,
  input logic              core_rx_rd,
  input logic [DATA_W-1:0] core_rx_data,
  input logic              core_tx_wr,
  input logic [DATA_W-1:0] core_tx_wdata,
  input logic              host_tx_rd,
  input logic [DATA_W-1:0] host_tx_data,
  input logic              host_ctl_wr,
  input logic [31:0]       host_ctl_data,
  input logic              core_retire,
  input logic [STAT_W-1:0] stat_word
);
  localparam logic [STAT_W-1:0] LIVE_MASK =
    (STAT_W'(1) << BIT_RXFULL) | (STAT_W'(1) << BIT_TXFULL) | (STAT_W'(1) << BIT_RETIRED);
  logic clr;
  assign clr = host_ctl_wr & host_ctl_data[CTL_CLR_BIT];

  assert_rx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_rx_wr |=> stat_word[BIT_RXFULL] && core_rx_data == $past(host_rx_wdata));
  assert_rx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rx_wr && !core_rx_rd) |=> $stable(stat_word[BIT_RXFULL]));
  assert_rx_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rx_rd && !host_rx_wr) |=> !stat_word[BIT_RXFULL]);
  assert_tx_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_tx_wr |=> stat_word[BIT_TXFULL] && host_tx_data == $past(core_tx_wdata));
  assert_tx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_tx_rd && !core_tx_wr) |=> !stat_word[BIT_TXFULL]);
  assert_retire_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_retire |=> stat_word[BIT_RETIRED]);
  assert_retire_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[BIT_RETIRED] && !clr) |=> stat_word[BIT_RETIRED]);
  assert_retire_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !core_retire) |=> !stat_word[BIT_RETIRED]);
  assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word & ~LIVE_MASK) == '0);
endmodule

bind dbgcc_top dbgcc_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .host_rx_wr(host_rx_wr), .host_rx_wdata(host_rx_wdata),
  .core_rx_rd(core_rx_rd), .core_rx_data(core_rx_data),
  .core_tx_wr(core_tx_wr), .core_tx_wdata(core_tx_wdata),
  .host_tx_rd(host_tx_rd), .host_tx_data(host_tx_data),
  .host_ctl_wr(host_ctl_wr), .host_ctl_data(host_ctl_data),
  .core_retire(core_retire), .stat_word(stat_word)
);

// File: tb/sim_dbgcc_top.sv
`timescale 1ns/1ps
module sim_dbgcc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_rx_wr = 0, core_rx_rd = 0, core_tx_wr = 0, host_tx_rd = 0;
  logic        host_ctl_wr = 0, core_retire = 0;
  logic [31:0] host_rx_wdata = 0, core_tx_wdata = 0, host_ctl_data = 0;
  logic [31:0] core_rx_data, host_tx_data, stat_word;

  always #10 clk = ~clk;

  dbgcc_top u0 (
    .clk(clk), .rst_n(rst_n),
    .host_rx_wr(host_rx_wr), .host_rx_wdata(host_rx_wdata),
    .core_rx_rd(core_rx_rd), .core_rx_data(core_rx_data),
    .core_tx_wr(core_tx_wr), .core_tx_wdata(core_tx_wdata),
    .host_tx_rd(host_tx_rd), .host_tx_data(host_tx_data),
    .host_ctl_wr(host_ctl_wr), .host_ctl_data(host_ctl_data),
    .core_retire(core_retire), .stat_word(stat_word)
  );

  typedef struct {
    string       tag;
    logic [31:0] stat;
    bit          rx_ok;
    logic [31:0] rx;
    bit          tx_ok;
    logic [31:0] tx;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit m_rxf = 0, m_txf = 0, m_adv = 0;
  logic [31:0] m_rx = 0, m_tx = 0;

  // Driver: applies one cycle of strobes, updates the model, queues the expectation.
  task automatic op(string tag, bit rxw, logic [31:0] rxd, bit rxr,
                    bit txw, logic [31:0] txd, bit txr,
                    bit ctlw, logic [31:0] ctld, bit ret);
    item_t it;
    @(negedge clk); #1;
    host_rx_wr = rxw; host_rx_wdata = rxd; core_rx_rd = rxr;
    core_tx_wr = txw; core_tx_wdata = txd; host_tx_rd = txr;
    host_ctl_wr = ctlw; host_ctl_data = ctld; core_retire = ret;
    @(posedge clk); #1;
    host_rx_wr = 0; core_rx_rd = 0; core_tx_wr = 0; host_tx_rd = 0;
    host_ctl_wr = 0; core_retire = 0;
    m_rxf = rxw | (m_rxf & ~rxr);
    if (rxw) m_rx = rxd;
    m_txf = txw | (m_txf & ~txr);
    if (txw) m_tx = txd;
    m_adv = ret | (m_adv & ~(ctlw & ctld[3]));
    it.tag = tag;
    it.stat = (32'(m_rxf) << 30) | (32'(m_txf) << 29) | (32'(m_adv) << 25);
    it.rx_ok = m_rxf; it.rx = m_rx;
    it.tx_ok = m_txf; it.tx = m_tx;
    q.push_back(it);
  endtask

  task automatic idle(string tag);
    op(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // Monitor: compares outputs at the falling edge after each driven cycle.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (stat_word !== it.stat) begin
        errors++;
        $display("FAIL %s status: actual %h expected %h", it.tag, stat_word, it.stat);
      end
      if (it.rx_ok) begin
        checks++;
        if (core_rx_data !== it.rx) begin
          errors++;
          $display("FAIL %s inbound word: actual %h expected %h", it.tag, core_rx_data, it.rx);
        end
      end
      if (it.tx_ok) begin
        checks++;
        if (host_tx_data !== it.tx) begin
          errors++;
          $display("FAIL %s outbound word: actual %h expected %h", it.tag, host_tx_data, it.tx);
        end
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle("R1 reset");
    op("R2 deposit", 1, 32'hA5A5_0001, 0, 0, 0, 0, 0, 0, 0);
    idle("R2 hold");
    op("R3 collect", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    op("R4 core deposit", 0, 0, 0, 1, 32'h1234_5678, 0, 0, 0, 0);
    op("R6 overwrite", 0, 0, 0, 1, 32'hCAFE_F00D, 0, 0, 0, 0);
    op("R5 collect", 0, 0, 0, 0, 0, 1, 0, 0, 0);
    op("R7 retire", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R7 sticky idle");
    op("R7 sticky traffic", 1, 32'h0BAD_BEEF, 0, 1, 32'h0F0F_0F0F, 0, 0, 0, 0);
    op("R8 ctl no clear bit", 0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFF7, 0);
    op("R8 ctl clear", 0, 0, 0, 0, 0, 0, 1, 32'h0000_0008, 0);
    op("R9 retire with clear", 0, 0, 0, 0, 0, 0, 1, 32'h0000_0008, 1);
    op("R8 ctl all ones", 0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, 0);
    op("R10 refill", 1, 32'h1111_2222, 0, 0, 0, 0, 0, 0, 0);
    op("R10 deposit with collect", 1, 32'h3333_4444, 1, 0, 0, 0, 0, 0, 0);
    op("R11 refill", 0, 0, 0, 1, 32'h5555_6666, 0, 0, 0, 0);
    op("R11 deposit with collect", 0, 0, 0, 1, 32'h7777_8888, 1, 0, 0, 0);
    op("R12 all live set", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    op("R3 drain both", 0, 0, 1, 0, 0, 1, 0, 0, 0);
    idle("R12 quiet");
    @(negedge clk); @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule